// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block is a streaming moving-target-indication filter placed between a range-processing stage and a Doppler stage. Signed I/Q samples arrive one at a time, each tagged with its range-bin index, and a chirp is one pass over all range bins. For every bin the block keeps the raw sample from the previous chirp. It emits the current sample minus that stored sample, computed separately for I and for Q. Returns from stationary scatterers are the same from chirp to chirp, so they cancel, and only the change from chirp to chirp reaches the Doppler stage.

An enable input selects between this cancelling mode and a plain pass-through. While no complete previous chirp is held, the cancelling mode sends zeros and a status output is raised. This covers the first chirp after reset and the first chirp after the mode is switched on. Differences that do not fit in the data width are clamped to the signed limits.

Top module: `pulse_canceller`

## Requirements
- R1: With `enable_i` low, a valid input appears one clock later on `i_o`, `q_o` and `bin_o` unchanged.
- R2: `valid_o` is high in exactly the clock after each clock with `valid_i` high, and in no other clock. When `valid_o` is low, `i_o` and `q_o` are zero. Input valid may arrive on any clock and is never refused.
- R3: When `valid_o` is high, `bin_o` equals the `bin_i` of the sample it belongs to.
- R4: With `enable_i` high and history valid, the output for bin b is the current sample minus the raw sample last stored for bin b, for I and Q independently. Identical consecutive chirps therefore give exactly zero.
- R5: With `enable_i` high and history not valid, valid outputs are zero, and the input is still stored as history. `first_chirp_o` is high exactly while history is not valid.
- R6: History becomes valid in the clock after bin NUM_BINS−1 (63 by default) has been stored with `enable_i` high. That sample itself is still muted when it arrives without history.
- R7: Any clock with `enable_i` low clears history. After the mode is re-enabled, the next chirp is muted.
- R8: A difference above the positive limit gives 2^(DATA_W−1)−1 (+32767 at 16 bits). A difference below the negative limit gives −2^(DATA_W−1) (−32768).
- R9: While `rst_n` is low, `valid_o` is low, `i_o`/`q_o` are zero and `first_chirp_o` is high. The first chirp after reset is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | 1 = cancel mode, 0 = pass-through |
| valid_i | input | 1 | Input sample strobe |
| bin_i | input | BIN_W | Range-bin index of the input sample |
| i_i | input | DATA_W | Signed in-phase input |
| q_i | input | DATA_W | Signed quadrature input |
| valid_o | output | 1 | Output sample strobe |
| bin_o | output | BIN_W | Range-bin index of the output sample |
| i_o | output | DATA_W | Signed in-phase output |
| q_o | output | DATA_W | Signed quadrature output |
| first_chirp_o | output | 1 | High while no complete history is held |

## Verification
The assertions check the following on every clock:
- The one-clock valid and bin forwarding, the zero data on idle clocks and the unchanged pass-through values.
- The muting of samples taken while history is missing, and the clearing of history by a low enable.

The arithmetic of the difference needs a model of the per-bin history, so only the bench's scenarios can show it:
- Cancellation of repeated chirps and the isolation of a single changed bin.
- Clamping at both signed limits.
- The exact clock at which history becomes valid after the last bin.
- Recovery from a reset in the middle of a chirp.

// File: rtl/pc_pkg.sv
package pc_pkg;
    // Sample lanes handled side by side
    typedef enum int {
        LANE_I = 0,
        LANE_Q = 1
    } lane_e;

    localparam int PC_LANES = 2;
endpackage

// File: rtl/pc_hist_mem.sv
module pc_hist_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store_q [DEPTH];

    // Read before write: the old chirp's value is seen in the write cycle
    assign rdata = store_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[addr] <= wdata;
        end
    end
endmodule

// File: rtl/pc_sat_sub.sv
module pc_sat_sub #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] cur,
    input  logic signed [W-1:0] prev,
    output logic signed [W-1:0] diff
);
    localparam logic signed [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {cur[W-1], cur} - {prev[W-1], prev};
        if (wide[W] != wide[W-1]) begin
            diff = wide[W] ? NEG_LIM : POS_LIM;
        end else begin
            diff = wide[W-1:0];
        end
    end
endmodule

// File: rtl/pulse_canceller.sv
module pulse_canceller #(
    parameter int NUM_BINS = 64,
    parameter int DATA_W   = 16,
    parameter int BIN_W    = $clog2(NUM_BINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable_i,
    input  logic                     valid_i,
    input  logic [BIN_W-1:0]         bin_i,
    input  logic signed [DATA_W-1:0] i_i,
    input  logic signed [DATA_W-1:0] q_i,
    output logic                     valid_o,
    output logic [BIN_W-1:0]         bin_o,
    output logic signed [DATA_W-1:0] i_o,
    output logic signed [DATA_W-1:0] q_o,
    output logic                     first_chirp_o
);
    import pc_pkg::*;

    localparam int                 MEM_W    = PC_LANES * DATA_W;
    localparam logic [BIN_W-1:0]   LAST_BIN = BIN_W'(NUM_BINS - 1);

    typedef struct packed {
        logic                     vld;
        logic [BIN_W-1:0]         bin;
        logic signed [DATA_W-1:0] i;
        logic signed [DATA_W-1:0] q;
        logic                     hist;
    } state_t;

    state_t st_d, st_q;

    logic [MEM_W-1:0]         wr_word;
    logic [MEM_W-1:0]         rd_word;
    logic signed [DATA_W-1:0] cur_lane  [PC_LANES];
    logic signed [DATA_W-1:0] diff_lane [PC_LANES];
    logic                     store_en;

    assign cur_lane[LANE_I] = i_i;
    assign cur_lane[LANE_Q] = q_i;
    assign store_en         = valid_i & enable_i;

    // Per-bin history of the raw samples of the previous chirp
    pc_hist_mem #(
        .DEPTH (NUM_BINS),
        .WIDTH (MEM_W),
        .AW    (BIN_W)
    ) u_hist (
        .clk   (clk),
        .wr_en (store_en),
        .addr  (bin_i),
        .wdata (wr_word),
        .rdata (rd_word)
    );

    // One subtractor per lane
    for (genvar ln = 0; ln < PC_LANES; ln++) begin : g_lane
        assign wr_word[ln*DATA_W +: DATA_W] = cur_lane[ln];

        pc_sat_sub #(
            .W (DATA_W)
        ) u_sub (
            .cur  (cur_lane[ln]),
            .prev (rd_word[ln*DATA_W +: DATA_W]),
            .diff (diff_lane[ln])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        st_d.bin = valid_i ? bin_i : '0;
        st_d.i   = '0;
        st_d.q   = '0;
        if (valid_i) begin
            if (!enable_i) begin
                st_d.i = i_i;
                st_d.q = q_i;
            end else if (st_q.hist) begin
                st_d.i = diff_lane[LANE_I];
                st_d.q = diff_lane[LANE_Q];
            end
        end
        if (!enable_i) begin
            st_d.hist = 1'b0;
        end else if (valid_i && bin_i == LAST_BIN) begin
            st_d.hist = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o       = st_q.vld;
    assign bin_o         = st_q.bin;
    assign i_o           = st_q.i;
    assign q_o           = st_q.q;
    assign first_chirp_o = ~st_q.hist;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);                                                // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && i_o == '0 && q_o == '0));                  // R2
    AST_BIN_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (bin_o == $past(bin_i)));                                // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !enable_i) |=> (i_o == $past(i_i) && q_o == $past(q_i))); // R1
    AST_MUTE_NO_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && enable_i && first_chirp_o) |=> (i_o == '0 && q_o == '0)); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> first_chirp_o);                                        // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (!valid_o && first_chirp_o));                             // R9
endmodule

// File: tb/pulse_canceller_bench.sv
module pulse_canceller_bench;
    localparam int NB    = 64;
    localparam int W     = 16;
    localparam int BW    = 6;
    localparam int MAXV  = (1 << (W - 1)) - 1;
    localparam int MINV  = -(1 << (W - 1));

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable_i;
    logic          valid_i;
    logic [BW-1:0] bin_i;
    logic signed [W-1:0] i_i, q_i;
    logic          valid_o;
    logic [BW-1:0] bin_o;
    logic signed [W-1:0] i_o, q_o;
    logic          first_chirp_o;

    always #4 clk = ~clk;

    pulse_canceller #(.NUM_BINS(NB), .DATA_W(W)) u_pulse_canceller (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .valid_i(valid_i),
        .bin_i(bin_i), .i_i(i_i), .q_i(q_i), .valid_o(valid_o),
        .bin_o(bin_o), .i_o(i_o), .q_o(q_o), .first_chirp_o(first_chirp_o)
    );

    // Reference model state
    int  hist_i [NB];
    int  hist_q [NB];
    bit  hv;
    bit  e_vld;
    int  e_bin, e_i, e_q;
    int  n_checks = 0;
    int  n_fail   = 0;

    function automatic int clamp(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic compare(input string req);
        check(req, "valid_o", int'(valid_o), int'(e_vld));
        check(req, "i_o", int'(i_o), e_i);
        check(req, "q_o", int'(q_o), e_q);
        check(req, "first_chirp_o", int'(first_chirp_o), int'(!hv));
        if (e_vld) check(req, "bin_o", int'(bin_o), e_bin);
    endtask

    // Drive one clock of input right after a falling edge, then check at the next one
    task automatic tick(input bit en, input bit v, input int bin, input int iv, input int qv,
                        input string req);
        enable_i = en;
        valid_i  = v;
        bin_i    = BW'(bin);
        i_i      = W'(iv);
        q_i      = W'(qv);
        e_vld = v;
        e_bin = bin;
        e_i   = 0;
        e_q   = 0;
        if (v) begin
            if (!en) begin
                e_i = iv;
                e_q = qv;
            end else begin
                if (hv) begin
                    e_i = clamp(iv - hist_i[bin]);
                    e_q = clamp(qv - hist_q[bin]);
                end
                hist_i[bin] = iv;
                hist_q[bin] = qv;
            end
        end
        if (!en) hv = 1'b0;
        else if (v && bin == NB - 1) hv = 1'b1;
        @(negedge clk);
        compare(req);
    endtask

    task automatic chirp(input bit en, input int iv, input int qv, input int gap, input string req);
        for (int b = 0; b < NB; b++) begin
            tick(en, 1'b1, b, iv, qv, req);
            for (int g = 0; g < gap; g++) tick(en, 1'b0, 0, 0, 0, req);
        end
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        valid_i = 1'b0;
        hv = 1'b0;
        e_vld = 1'b0; e_i = 0; e_q = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare("R9");
        end
        rst_n = 1'b1;
    endtask

    task automatic run_all;
        // Reset state
        enable_i = 1'b0; bin_i = '0; i_i = '0; q_i = '0;
        do_reset(3);
        // R1 R3: pass-through with a ramp, plus idle gaps for R2
        for (int b = 0; b < NB; b++) tick(1'b0, 1'b1, b, 100 * b - 3000, -7 * b, "R1");
        chirp(1'b0, 1234, -4321, 1, "R2");
        // R5: first chirp muted, R6: history after last bin
        chirp(1'b1, 5000, 3000, 0, "R5");
        check("R6", "history after last bin", int'(first_chirp_o), 0);
        // R4: difference, then stationary cancellation
        chirp(1'b1, 7000, 4000, 0, "R4");
        chirp(1'b1, 7000, 4000, 2, "R4");
        for (int b = 0; b < NB; b++)
            tick(1'b1, 1'b1, b, (b == 20) ? 11000 : 7000, (b == 20) ? 1000 : 4000, "R4");
        // Negative values
        chirp(1'b1, -3000, -1000, 0, "R4");
        chirp(1'b1, -1000, -500, 0, "R4");
        // R8: both limits
        chirp(1'b1, -32000, 32000, 0, "R8");
        chirp(1'b1, 32000, -32000, 0, "R8");
        check("R8", "positive clamp", int'(i_o), MAXV);
        check("R8", "negative clamp", int'(q_o), MINV);
        chirp(1'b1, -32768, 32767, 0, "R8");
        // R7: one disabled clock, then the next chirp is muted
        tick(1'b0, 1'b0, 0, 0, 0, "R7");
        check("R7", "cleared by disable", int'(first_chirp_o), 1);
        chirp(1'b1, 2000, 1000, 0, "R7");
        chirp(1'b1, 2500, 500, 0, "R7");
        // R6: partial chirp keeps history invalid until the last bin
        tick(1'b0, 1'b0, 0, 0, 0, "R6");
        for (int b = 0; b < NB - 1; b++) tick(1'b1, 1'b1, b, 400, 400, "R6");
        check("R6", "still no history", int'(first_chirp_o), 1);
        tick(1'b1, 1'b1, NB - 1, 900, 900, "R6");
        check("R6", "last bin sample muted", int'(i_o), 0);
        chirp(1'b1, 1400, 100, 0, "R6");
        // R9: reset in the middle of a chirp
        for (int b = 0; b < 10; b++) tick(1'b1, 1'b1, b, 50, 60, "R9");
        do_reset(2);
        chirp(1'b1, 800, 900, 0, "R9");
        chirp(1'b1, 1800, 600, 0, "R9");
    endtask

    initial begin
        bit timed_out = 1'b0;
        rst_n = 1'b0;
        valid_i = 1'b0;
        enable_i = 1'b0;
        hv = 1'b0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule